// File: doc/BRIEF.md
# USB Device Status and Control Register

This block is an eight-bit status and control register for the firmware side of a USB device controller. Firmware writes it through a simple CPU write port and reads it back as a continuous value. The serial interface engine drives its own events into the same register: a strobe on each successful SETUP transaction, a strobe on bus activity, the EP0 FIFO busy level, and completion strobes when the controller has finished with a FIFO.

Each bit has one owner and one clear rule. The Stall bit is ordinary read/write for firmware, and a good SETUP clears it. The endpoint request bits and the remote-wakeup bit work differently: firmware can only set them, and only hardware clears them. Two bits are pure hardware status. One of them comes from an embedded idle timer, which flags a bus suspend after a parameterised idle time that defaults to 3.0 ms.

Four mirror outputs expose the control bits directly to the protocol engine:
- the stall request,
- the resume request,
- the two transmit requests.

Top module: `usb_dev_stat_reg`

## Requirements
- R1: After reset every register bit reads 0 and all four request outputs are 0.
- R2: Bit 0 (stall) takes the value of write data bit 0 on every write. Without a write or a SETUP strobe it holds. stall_req_o always equals bit 0.
- R3: A successful-SETUP strobe clears bit 0 on the next edge. This holds even when the same cycle carries a firmware write of 1 to that bit.
- R4: Bit 1 reads the EP0 FIFO busy input. Writes cannot change it.
- R5: Bit 2 (suspend) reads 1 once the bus-activity strobe has been low for IDLE_CYC consecutive edges after the last activity or reset, with IDLE_CYC = CLK_KHZ*IDLE_US/1000. It reads 0 one edge earlier. It then stays 1 while the bus remains idle.
- R6: A bus-activity strobe clears bit 2 on the next edge and restarts the full idle count.
- R7: Writing 1 to bit 3 (resume) sets it. Writing 0 has no effect. resume_req_o equals bit 3.
- R8: Bit 3 is cleared on the same edge that bit 2 falls from 1 to 0.
- R9: Writing 1 to bit 6 (EP0 transmit) or bit 5 (EP1 transmit) sets that bit, and writing 0 has no effect. The EP0 or EP1 read-done strobe clears the matching bit. ep0_tx_req_o and ep1_tx_req_o equal bits 6 and 5.
- R10: Writing 1 to bit 7 (EP0 receive) sets it, and writing 0 has no effect. The EP0 write-done strobe clears it.
- R11: For bits 3, 5, 6 and 7, a hardware clear in the same cycle as a firmware write of 1 leaves the bit at 0.
- R12: Bit 4 always reads 0. Writes to bits 1, 2 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Firmware write strobe |
| wr_data_i | input | 8 | Firmware write data |
| rd_data_o | output | 8 | Current register value |
| bus_act_i | input | 1 | Bus activity strobe |
| setup_ok_i | input | 1 | Successful SETUP strobe |
| ep0_busy_i | input | 1 | EP0 FIFO access in progress |
| ep0_rd_done_i | input | 1 | Controller finished reading EP0 FIFO |
| ep1_rd_done_i | input | 1 | Controller finished reading EP1 FIFO |
| ep0_wr_done_i | input | 1 | Controller finished writing EP0 FIFO |
| stall_req_o | output | 1 | Stall request |
| resume_req_o | output | 1 | Remote wakeup request |
| ep0_tx_req_o | output | 1 | EP0 transmit request |
| ep1_tx_req_o | output | 1 | EP1 transmit request |

## Verification
The case hardest to reach is the resume bit's hardware clear. Bit 3 is cleared only when suspend falls, so the bus must first stay idle for the full count, and only then may an activity strobe arrive. The bench sets up that case by pulsing activity to restart the timer from a known edge. It then waits exactly the idle count, checking the suspend bit one edge before and on the expected edge. Finally it pulses activity once to observe resume clearing. The same idle wait is repeated with a firmware set of resume landing in the very cycle of that activity strobe, which exercises the clear-wins rule.

// File: rtl/usb_stat_pkg.sv
package usb_stat_pkg;
  localparam int REG_W  = 8;
  localparam int FLAG_N = 5;

  localparam int BIT_STALL   = 0;
  localparam int BIT_BUSY    = 1;
  localparam int BIT_SUSP    = 2;
  localparam int BIT_RESUME  = 3;
  localparam int BIT_EP1_TX  = 5;
  localparam int BIT_EP0_TX  = 6;
  localparam int BIT_EP0_RX  = 7;

  typedef enum logic {FLAG_SET_ONLY = 1'b0, FLAG_RW = 1'b1} flag_kind_e;

  // flag slot -> register bit
  function automatic int flag_pos(int idx);
    case (idx)
      0:       return BIT_STALL;
      1:       return BIT_RESUME;
      2:       return BIT_EP1_TX;
      3:       return BIT_EP0_TX;
      default: return BIT_EP0_RX;
    endcase
  endfunction

  function automatic flag_kind_e flag_kind(int idx);
    return (idx == 0) ? FLAG_RW : FLAG_SET_ONLY;
  endfunction
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int TERM = 750000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic idle_o
);
  localparam int CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] TERM_C = CW'(TERM);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (act_i)           cnt_q <= '0;
    else if (cnt_q != TERM_C) cnt_q <= cnt_q + 1'b1;
  end

  assign idle_o = (cnt_q == TERM_C);
endmodule

// File: rtl/usb_stat_flag.sv
module usb_stat_flag
  import usb_stat_pkg::*;
#(
  parameter flag_kind_e KIND = FLAG_SET_ONLY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clr_i)  q_q <= 1'b0;   // hardware clear wins
    else if (wr_i) begin
      if (KIND == FLAG_RW) q_q <= wr_val_i;
      else if (wr_val_i)   q_q <= 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/usb_dev_stat_reg.sv
module usb_dev_stat_reg
  import usb_stat_pkg::*;
#(
  parameter int CLK_KHZ = 250000,
  parameter int IDLE_US = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              bus_act_i,
  input  logic              setup_ok_i,
  input  logic              ep0_busy_i,
  input  logic              ep0_rd_done_i,
  input  logic              ep1_rd_done_i,
  input  logic              ep0_wr_done_i,
  output logic              stall_req_o,
  output logic              resume_req_o,
  output logic              ep0_tx_req_o,
  output logic              ep1_tx_req_o
);
  localparam int IDLE_RAW = CLK_KHZ * IDLE_US / 1000;
  localparam int IDLE_CYC = (IDLE_RAW < 1) ? 1 : IDLE_RAW;

  logic              susp;
  logic [FLAG_N-1:0] flag_q;
  logic [FLAG_N-1:0] flag_clr;
  logic              unused_wr;

  assign unused_wr = ^{wr_data_i[4], wr_data_i[2:1]};

  usb_idle_timer #(.TERM(IDLE_CYC)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (bus_act_i),
    .idle_o (susp)
  );

  // clear sources per flag slot (see flag_pos)
  assign flag_clr[0] = setup_ok_i;
  assign flag_clr[1] = susp & bus_act_i;   // suspend about to fall
  assign flag_clr[2] = ep1_rd_done_i;
  assign flag_clr[3] = ep0_rd_done_i;
  assign flag_clr[4] = ep0_wr_done_i;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    usb_stat_flag #(.KIND(flag_kind(i))) u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i),
      .wr_val_i (wr_data_i[POS]),
      .clr_i    (flag_clr[i]),
      .q_o      (flag_q[i])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < FLAG_N; i++) rd_data_o[flag_pos(i)] = flag_q[i];
    rd_data_o[BIT_BUSY] = ep0_busy_i;
    rd_data_o[BIT_SUSP] = susp;
  end

  assign stall_req_o  = flag_q[0];
  assign resume_req_o = flag_q[1];
  assign ep1_tx_req_o = flag_q[2];
  assign ep0_tx_req_o = flag_q[3];
endmodule

// File: rtl/usb_dev_stat_reg_chk.sv
module usb_dev_stat_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] rd_data_o,
  input logic       bus_act_i,
  input logic       setup_ok_i,
  input logic       ep0_rd_done_i,
  input logic       ep1_rd_done_i,
  input logic       ep0_wr_done_i,
  input logic       stall_req_o,
  input logic       resume_req_o,
  input logic       ep0_tx_req_o,
  input logic       ep1_tx_req_o
);
  p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !setup_ok_i) |=> $stable(stall_req_o));

  p_stall_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_ok_i |=> !stall_req_o);

  p_susp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[2] && !bus_act_i) |=> rd_data_o[2]);

  p_susp_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |=> !rd_data_o[2]);

  p_resume_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_req_o && !(rd_data_o[2] && bus_act_i)) |=> resume_req_o);

  p_resume_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[2]) |-> !resume_req_o);

  p_ep0_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep0_rd_done_i |=> !ep0_tx_req_o);

  p_ep1_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep1_rd_done_i |=> !ep1_tx_req_o);

  p_ep0rx_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep0_wr_done_i |=> !rd_data_o[7]);
endmodule

bind usb_dev_stat_reg usb_dev_stat_reg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .rd_data_o     (rd_data_o),
  .bus_act_i     (bus_act_i),
  .setup_ok_i    (setup_ok_i),
  .ep0_rd_done_i (ep0_rd_done_i),
  .ep1_rd_done_i (ep1_rd_done_i),
  .ep0_wr_done_i (ep0_wr_done_i),
  .stall_req_o   (stall_req_o),
  .resume_req_o  (resume_req_o),
  .ep0_tx_req_o  (ep0_tx_req_o),
  .ep1_tx_req_o  (ep1_tx_req_o)
);

// File: tb/usb_dev_stat_reg_bench.sv
`timescale 1ns/1ps
module usb_dev_stat_reg_bench;
  localparam int CLK_KHZ = 10;
  localparam int IDLE_US = 3000;
  localparam int TERM    = CLK_KHZ * IDLE_US / 1000;  // 30

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       bus_act_i = 1'b0, setup_ok_i = 1'b0, ep0_busy_i = 1'b0;
  logic       ep0_rd_done_i = 1'b0, ep1_rd_done_i = 1'b0, ep0_wr_done_i = 1'b0;
  logic       stall_req_o, resume_req_o, ep0_tx_req_o, ep1_tx_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_dev_stat_reg #(.CLK_KHZ(CLK_KHZ), .IDLE_US(IDLE_US)) u_usb_dev_stat_reg (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .bus_act_i(bus_act_i), .setup_ok_i(setup_ok_i),
    .ep0_busy_i(ep0_busy_i), .ep0_rd_done_i(ep0_rd_done_i),
    .ep1_rd_done_i(ep1_rd_done_i), .ep0_wr_done_i(ep0_wr_done_i),
    .stall_req_o(stall_req_o), .resume_req_o(resume_req_o),
    .ep0_tx_req_o(ep0_tx_req_o), .ep1_tx_req_o(ep1_tx_req_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle strobes; return at the negedge after the sampling edge
  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic act_pulse();
    @(negedge clk); bus_act_i = 1'b1;
    @(negedge clk); bus_act_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reg", rd_data_o, 8'h00);
    chk("R1 outs", {4'h0, stall_req_o, resume_req_o, ep0_tx_req_o, ep1_tx_req_o}, 8'h00);
  endtask

  task automatic t_stall();
    wr(8'h01);
    chk("R2 stall set", {7'h0, rd_data_o[0]}, 8'h01);
    chk("R2 stall_req", {7'h0, stall_req_o}, 8'h01);
    wr(8'h00);
    chk("R2 stall clr by fw", {7'h0, stall_req_o}, 8'h00);
    wr(8'h01);
    @(negedge clk); setup_ok_i = 1'b1;
    @(negedge clk); setup_ok_i = 1'b0;
    chk("R3 setup clears", {7'h0, rd_data_o[0]}, 8'h00);
    @(negedge clk); setup_ok_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h01;
    @(negedge clk); setup_ok_i = 1'b0; wr_en_i = 1'b0;
    chk("R3 setup beats write", {7'h0, stall_req_o}, 8'h00);
  endtask

  task automatic t_ro_bits();
    ep0_busy_i = 1'b1;
    wr(8'h00);
    chk("R4 busy reads 1", {7'h0, rd_data_o[1]}, 8'h01);
    ep0_busy_i = 1'b0;
    wr(8'h02);
    chk("R4 busy write ignored", {7'h0, rd_data_o[1]}, 8'h00);
    act_pulse();
    wr(8'h16);
    chk("R12 bits 1,2,4 ignore writes", rd_data_o & 8'h16, 8'h00);
  endtask

  task automatic t_suspend();
    act_pulse();
    repeat (TERM - 1) @(negedge clk);
    chk("R5 suspend not early", {7'h0, rd_data_o[2]}, 8'h00);
    @(negedge clk);
    chk("R5 suspend on time", {7'h0, rd_data_o[2]}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R5 suspend holds", {7'h0, rd_data_o[2]}, 8'h01);
    act_pulse();
    chk("R6 activity clears", {7'h0, rd_data_o[2]}, 8'h00);
    repeat (TERM - 1) @(negedge clk);
    chk("R6 count restarted", {7'h0, rd_data_o[2]}, 8'h00);
    @(negedge clk);
    chk("R6 suspend again", {7'h0, rd_data_o[2]}, 8'h01);
  endtask

  task automatic t_resume();
    act_pulse();
    wr(8'h08);
    chk("R7 resume set", {7'h0, resume_req_o}, 8'h01);
    wr(8'h00);
    chk("R7 write 0 ignored", {7'h0, rd_data_o[3]}, 8'h01);
    repeat (TERM) @(negedge clk);
    chk("R7 held through suspend", {6'h0, rd_data_o[3], rd_data_o[2]}, 8'h03);
    act_pulse();
    chk("R8 resume cleared on suspend fall", {6'h0, rd_data_o[3], rd_data_o[2]}, 8'h00);
    repeat (TERM) @(negedge clk);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h08; bus_act_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; bus_act_i = 1'b0;
    chk("R11 resume clear beats set", {7'h0, resume_req_o}, 8'h00);
  endtask

  task automatic t_ep_tx();
    wr(8'h60);
    chk("R9 tx set", {6'h0, ep0_tx_req_o, ep1_tx_req_o}, 8'h03);
    wr(8'h00);
    chk("R9 write 0 ignored", rd_data_o & 8'h60, 8'h60);
    @(negedge clk); ep1_rd_done_i = 1'b1;
    @(negedge clk); ep1_rd_done_i = 1'b0;
    chk("R9 ep1 done", {6'h0, ep0_tx_req_o, ep1_tx_req_o}, 8'h02);
    @(negedge clk); ep0_rd_done_i = 1'b1;
    @(negedge clk); ep0_rd_done_i = 1'b0;
    chk("R9 ep0 done", rd_data_o & 8'h60, 8'h00);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h20; ep1_rd_done_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; ep1_rd_done_i = 1'b0;
    chk("R11 ep1 clear beats set", {7'h0, ep1_tx_req_o}, 8'h00);
  endtask

  task automatic t_ep0_rx();
    wr(8'h80);
    chk("R10 rx set", rd_data_o & 8'h80, 8'h80);
    wr(8'h00);
    chk("R10 write 0 ignored", rd_data_o & 8'h80, 8'h80);
    @(negedge clk); ep0_wr_done_i = 1'b1;
    @(negedge clk); ep0_wr_done_i = 1'b0;
    chk("R10 done clears", rd_data_o & 8'h80, 8'h00);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h80; ep0_wr_done_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; ep0_wr_done_i = 1'b0;
    chk("R11 rx clear beats set", rd_data_o & 8'h80, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_ro_bits();
    t_suspend();
    t_resume();
    t_ep_tx();
    t_ep0_rx();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule